// File: doc/BRIEF.md
# Event Framing Unit with Trigger Counters

This block sits beside one readout processor and wraps each event payload in a fixed frame. In the background it counts level-1 accept strobes and level-1 reject strobes in two free-running counters, and on every accept it captures the 12-bit bunch-crossing value. When a dump is requested, it freezes a snapshot of those counters, the captured crossing value, the processor identity, an upstream accept count, an error word and the payload length. It then streams a ten-word header, forwards the payload words from the source, adds one filler word when that is needed to make the data block even, and closes with two trailer words.

The output is a 32-bit stream with valid/ready flow control and a last flag. The payload source sees a ready signal that is only raised while payload words are being forwarded, so the source's pace and the sink's back-pressure both reach through the block.

Top module: `eventFramer`

## Requirements
- R1: After a dump request is accepted, the first ten output words are, in this order: 0xF000000F, total length, payload length, processor ID, upstream accept count (taken from the input port), bunch crossing, local accept count, local reject count, padding flag, error word.
- R2: The local accept and reject counters each increase by one per cycle in which their strobe is high, and both increase when both strobes are high in the same cycle; the header shows the counts of strobes seen before the request cycle.
- R3: The bunch-crossing header word (word 5) is the 12-bit value present on the crossing input at the most recent accept strobe, zero-extended to 32 bits; reject strobes do not change it.
- R4: The payload words follow the header unchanged and in order, exactly as many as the requested length (zero allowed).
- R5: When the payload length is odd, one word 0xDEADBEEF follows the payload and the padding flag word (word 8) is 1; when it is even, no filler is sent and the flag word is 0.
- R6: Header word 1 equals 12 plus the payload length plus the filler count; header word 2 equals the payload length.
- R7: The frame ends with two words 0xD000000D, and the last flag is high only with the second of them.
- R8: A dump request made while a frame is in progress is ignored: no second frame follows, and after the last word the output stays invalid until a new request.
- R9: A synchronous reset clears both counters and the captured crossing value and leaves the output invalid.
- R10: Trigger strobes arriving while a frame is being sent do not change that frame, but are counted for the next frame.
- R11: While the output is valid and not accepted, the word is held unchanged; the payload ready signal is low outside the payload phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1aStrobe | input | 1 | Level-1 accept strobe |
| l1rStrobe | input | 1 | Level-1 reject strobe |
| bcIn | input | 12 | Bunch-crossing value |
| upAccCount | input | 32 | Upstream accept count for the header |
| procId | input | 32 | Processor identity |
| errWord | input | 32 | Error word for the header |
| dumpReq | input | 1 | Request to send one frame |
| payLen | input | 16 | Payload length in words, sampled with the request |
| payData | input | 32 | Payload word from the source |
| payValid | input | 1 | Payload word valid |
| payReady | output | 1 | Block accepts a payload word |
| outData | output | 32 | Output stream word |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Sink accepts the output word |
| outLast | output | 1 | Marks the final word of a frame |

## Verification
The hardest case to reach from the ports is a trigger strobe and a second dump request landing in the middle of a frame that is already under way, because the snapshot must shield the current header while the live counters keep moving. The bench raises an accept strobe with a fresh crossing value and a dump request together while header words are still draining under back-pressure, then checks that the current frame is untouched, that no extra frame appears, and that the next frame's header carries the added count and new crossing value.

// File: rtl/eventFramerPkg.sv
package eventFramerPkg;
  localparam int unsigned HDR_WORDS = 10;
  localparam int unsigned TRL_WORDS = 2;
  localparam logic [31:0] HDR_KEY   = 32'hF000000F;
  localparam logic [31:0] FILL_WORD = 32'hDEADBEEF;
  localparam logic [31:0] TRL_WORD  = 32'hD000000D;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HDR,
    SEL_PAY,
    SEL_FILL,
    SEL_TRL
  } wordSel_e;

  typedef struct packed {
    logic     snap;
    wordSel_e sel;
    logic [3:0] hdrIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/eventFramerCtrl.sv
module eventFramerCtrl
  import eventFramerPkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dumpReq,
  input  logic [LEN_W-1:0] payLen,
  input  logic             payValid,
  input  logic             outReady,
  output logic             payReady,
  output logic             outValid,
  output logic             outLast,
  output ctlStrobe_t       ctl
);
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PAY, ST_FILL, ST_TRL} state_e;

  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};
  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_WORDS - 1);
  localparam logic [LEN_W-1:0] TRL_LAST = LEN_W'(TRL_WORDS - 1);

  state_e state;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] lenQ;
  logic fillQ;
  logic xfer;

  always_comb begin
    outValid = 1'b0;
    payReady = 1'b0;
    ctl.snap = 1'b0;
    ctl.sel = SEL_NONE;
    ctl.hdrIdx = idx[3:0];
    unique case (state)
      ST_IDLE: ctl.snap = dumpReq;
      ST_HDR:  begin outValid = 1'b1; ctl.sel = SEL_HDR; end
      ST_PAY:  begin outValid = payValid; payReady = outReady; ctl.sel = SEL_PAY; end
      ST_FILL: begin outValid = 1'b1; ctl.sel = SEL_FILL; end
      ST_TRL:  begin outValid = 1'b1; ctl.sel = SEL_TRL; end
      default: ;
    endcase
    outLast = (state == ST_TRL) && (idx == TRL_LAST);
    xfer = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      lenQ  <= '0;
      fillQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (dumpReq) begin
          state <= ST_HDR;
          idx   <= '0;
          lenQ  <= payLen;
          fillQ <= payLen[0];
        end
        ST_HDR: if (xfer) begin
          if (idx == HDR_LAST) begin
            idx <= '0;
            if (lenQ != '0)  state <= ST_PAY;
            else if (fillQ)  state <= ST_FILL;
            else             state <= ST_TRL;
          end else idx <= idx + ONE;
        end
        ST_PAY: if (xfer) begin
          if (idx == lenQ - ONE) begin
            idx   <= '0;
            state <= fillQ ? ST_FILL : ST_TRL;
          end else idx <= idx + ONE;
        end
        ST_FILL: if (xfer) begin
          idx   <= '0;
          state <= ST_TRL;
        end
        ST_TRL: if (xfer) begin
          if (idx == TRL_LAST) begin
            idx   <= '0;
            state <= ST_IDLE;
          end else idx <= idx + ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eventFramerData.sv
module eventFramerData
  import eventFramerPkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned BC_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l1aStrobe,
  input  logic             l1rStrobe,
  input  logic [BC_W-1:0]  bcIn,
  input  logic [31:0]      upAccCount,
  input  logic [31:0]      procId,
  input  logic [31:0]      errWord,
  input  logic [LEN_W-1:0] payLen,
  input  logic [31:0]      payData,
  input  ctlStrobe_t       ctl,
  output logic [31:0]      outData
);
  localparam int unsigned FRAME_FIXED = HDR_WORDS + TRL_WORDS;

  logic [CNT_W-1:0] accCnt, rejCnt, accQ, rejQ;
  logic [BC_W-1:0]  bcLive, bcQ;
  logic [31:0]      upQ, idQ, errQ;
  logic [LEN_W-1:0] lenQ;
  logic             fillQ;
  logic [31:0]      hdrWord;
  logic [31:0]      totalLen;

  always_ff @(posedge clk) begin
    if (rst) begin
      accCnt <= '0;
      rejCnt <= '0;
      bcLive <= '0;
    end else begin
      if (l1aStrobe) begin
        accCnt <= accCnt + CNT_W'(1);
        bcLive <= bcIn;
      end
      if (l1rStrobe) rejCnt <= rejCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0; rejQ <= '0; bcQ <= '0;
      upQ <= '0; idQ <= '0; errQ <= '0;
      lenQ <= '0; fillQ <= 1'b0;
    end else if (ctl.snap) begin
      accQ  <= accCnt;
      rejQ  <= rejCnt;
      bcQ   <= bcLive;
      upQ   <= upAccCount;
      idQ   <= procId;
      errQ  <= errWord;
      lenQ  <= payLen;
      fillQ <= payLen[0];
    end
  end

  assign totalLen = 32'(FRAME_FIXED) + 32'(lenQ) + 32'(fillQ);

  always_comb begin
    unique case (ctl.hdrIdx)
      4'd0:    hdrWord = HDR_KEY;
      4'd1:    hdrWord = totalLen;
      4'd2:    hdrWord = 32'(lenQ);
      4'd3:    hdrWord = idQ;
      4'd4:    hdrWord = upQ;
      4'd5:    hdrWord = 32'(bcQ);
      4'd6:    hdrWord = 32'(accQ);
      4'd7:    hdrWord = 32'(rejQ);
      4'd8:    hdrWord = 32'(fillQ);
      4'd9:    hdrWord = errQ;
      default: hdrWord = '0;
    endcase
    unique case (ctl.sel)
      SEL_HDR:  outData = hdrWord;
      SEL_PAY:  outData = payData;
      SEL_FILL: outData = FILL_WORD;
      SEL_TRL:  outData = TRL_WORD;
      default:  outData = '0;
    endcase
  end
endmodule

// File: rtl/eventFramer.sv
module eventFramer
  import eventFramerPkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned BC_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l1aStrobe,
  input  logic             l1rStrobe,
  input  logic [BC_W-1:0]  bcIn,
  input  logic [31:0]      upAccCount,
  input  logic [31:0]      procId,
  input  logic [31:0]      errWord,
  input  logic             dumpReq,
  input  logic [LEN_W-1:0] payLen,
  input  logic [31:0]      payData,
  input  logic             payValid,
  output logic             payReady,
  output logic [31:0]      outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             outLast
);
  ctlStrobe_t ctl;

  eventFramerCtrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .dumpReq(dumpReq), .payLen(payLen),
    .payValid(payValid), .outReady(outReady), .payReady(payReady),
    .outValid(outValid), .outLast(outLast), .ctl(ctl)
  );

  eventFramerData #(.LEN_W(LEN_W), .CNT_W(CNT_W), .BC_W(BC_W)) u_data (
    .clk(clk), .rst(rst), .l1aStrobe(l1aStrobe), .l1rStrobe(l1rStrobe),
    .bcIn(bcIn), .upAccCount(upAccCount), .procId(procId), .errWord(errWord),
    .payLen(payLen), .payData(payData), .ctl(ctl), .outData(outData)
  );
endmodule

// File: rtl/eventFramerChecker.sv
module eventFramerChecker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] payData,
  input logic        payValid,
  input logic        payReady,
  input logic [31:0] outData,
  input logic        outValid,
  input logic        outReady,
  input logic        outLast
);
  a_r7_last_on_trailer: assert property (@(posedge clk) disable iff (rst)
    outLast |-> (outValid && outData == 32'hD000000D));

  a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r4_payload_forwarded: assert property (@(posedge clk) disable iff (rst)
    (payReady && payValid) |-> (outValid && outData == payData));

  a_r8_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    (outLast && outValid && outReady) |=> !outValid);

  a_r9_reset_output_idle: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && !payReady));
endmodule

bind eventFramer eventFramerChecker u_chk (
  .clk(clk), .rst(rst), .payData(payData), .payValid(payValid),
  .payReady(payReady), .outData(outData), .outValid(outValid),
  .outReady(outReady), .outLast(outLast)
);

// File: tb/sim_eventFramer.sv
module sim_eventFramer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l1aStrobe = 1'b0, l1rStrobe = 1'b0;
  logic [11:0] bcIn = '0;
  logic [31:0] upAccCount = '0, procId = '0, errWord = '0;
  logic dumpReq = 1'b0;
  logic [15:0] payLen = '0;
  logic [31:0] payData = '0;
  logic payValid = 1'b0;
  logic payReady;
  logic [31:0] outData;
  logic outValid;
  logic outReady = 1'b0;
  logic outLast;

  always #5 clk = ~clk;

  eventFramer u0 (
    .clk(clk), .rst(rst), .l1aStrobe(l1aStrobe), .l1rStrobe(l1rStrobe),
    .bcIn(bcIn), .upAccCount(upAccCount), .procId(procId), .errWord(errWord),
    .dumpReq(dumpReq), .payLen(payLen), .payData(payData), .payValid(payValid),
    .payReady(payReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outLast(outLast)
  );

  int checks = 0;
  int fails = 0;
  int expAcc = 0, expRej = 0;
  logic [11:0] expBc = '0;
  logic [31:0] expW [64];

  // fields: acc[35:32] rej[31:28] both[27:24] bc[23:12] len[11:8] readyPattern[7:0]
  localparam logic [35:0] VEC [6] = '{
    {4'd0, 4'd0, 4'd0, 12'h000, 4'd4, 8'hFF},
    {4'd3, 4'd1, 4'd0, 12'h123, 4'd5, 8'hAA},
    {4'd0, 4'd2, 4'd2, 12'h7FF, 4'd0, 8'hFF},
    {4'd1, 4'd0, 4'd0, 12'hFFF, 4'd1, 8'h6D},
    {4'd5, 4'd5, 4'd1, 12'h456, 4'd7, 8'hB5},
    {4'd2, 4'd0, 4'd3, 12'h001, 4'd2, 8'hFF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int pos, input int n, input int fill);
    if (pos < 10) begin
      case (pos)
        1, 2: return "R6";
        5: return "R3";
        6, 7: return "R2/R10";
        8: return "R5";
        default: return "R1";
      endcase
    end
    if (pos < 10 + n) return "R4";
    if (pos < 10 + n + fill) return "R5";
    return "R7";
  endfunction

  task automatic pulse(input bit a, input bit r, input logic [11:0] bc);
    @(negedge clk);
    l1aStrobe = a; l1rStrobe = r; bcIn = bc;
    @(negedge clk);
    l1aStrobe = 1'b0; l1rStrobe = 1'b0; bcIn = ~bc;
    if (a) begin expAcc++; expBc = bc; end
    if (r) expRej++;
  endtask

  task automatic runFrame(input int n, input logic [7:0] rdyPat, input int tagId, input bit disturb);
    int total, fill, got, payIdx, cyc, lastCount;
    bit fired, stalled;
    logic [31:0] heldWord;
    fill = n % 2;
    total = 12 + n + fill;
    upAccCount = 32'h1000 + tagId;
    procId = 32'h3 + tagId;
    errWord = 32'hE0 + tagId;
    expW[0] = 32'hF000000F; expW[1] = total; expW[2] = n; expW[3] = procId;
    expW[4] = upAccCount; expW[5] = {20'b0, expBc}; expW[6] = expAcc;
    expW[7] = expRej; expW[8] = fill; expW[9] = errWord;
    for (int k = 0; k < n; k++) expW[10 + k] = 32'hA000_0000 + tagId * 256 + k;
    if (fill != 0) expW[10 + n] = 32'hDEADBEEF;
    expW[total - 2] = 32'hD000000D; expW[total - 1] = 32'hD000000D;
    @(negedge clk);
    dumpReq = 1'b1; payLen = 16'(n);
    @(negedge clk);
    dumpReq = 1'b0; payLen = 16'hFFFF;
    got = 0; payIdx = 0; cyc = 0; lastCount = 0; fired = 0; stalled = 0; heldWord = '0;
    while (got < total && cyc < 400) begin
      outReady = rdyPat[cyc % 8];
      payValid = 1'b1;
      payData = 32'hA000_0000 + tagId * 256 + payIdx;
      if (disturb && !fired && got == 3) begin
        l1aStrobe = 1'b1; bcIn = 12'hABC; dumpReq = 1'b1; fired = 1;
      end else begin
        l1aStrobe = 1'b0; dumpReq = 1'b0;
      end
      #1;
      if (stalled) check(outValid && outData == heldWord, "R11 hold", outData, heldWord);
      if (payReady && got < 10) check(0, "R11 payReady in header", 1, 0);
      stalled = outValid && !outReady;
      heldWord = outData;
      if (outValid && outReady) begin
        check(outData == expW[got], reqOf(got, n, fill), outData, expW[got]);
        if (outLast) begin
          lastCount++;
          check(got == total - 1, "R7 last position", got, total - 1);
        end
        got++;
      end
      if (payReady && payValid) payIdx++;
      cyc++;
      @(negedge clk);
    end
    l1aStrobe = 1'b0; dumpReq = 1'b0; payValid = 1'b0; outReady = 1'b1;
    if (fired) begin expAcc++; expBc = 12'hABC; end
    check(got == total, "R4 frame length", got, total);
    check(lastCount == 1, "R7 last count", lastCount, 1);
    for (int k = 0; k < 4; k++) begin
      #1;
      check(!outValid, "R8 no extra frame", outValid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!outValid && !payReady && !outLast, "R9 reset outputs", {outValid, payReady, outLast}, 0);
    for (int e = 0; e < 6; e++) begin
      for (int i = 0; i < int'(VEC[e][35:32]); i++) pulse(1, 0, VEC[e][23:12]);
      for (int i = 0; i < int'(VEC[e][31:28]); i++) pulse(0, 1, VEC[e][23:12] ^ 12'h5A5);
      for (int i = 0; i < int'(VEC[e][27:24]); i++) pulse(1, 1, VEC[e][23:12]);
      runFrame(int'(VEC[e][11:8]), VEC[e][7:0], e, 0);
    end
    // R10 and R8: accept strobe and dump request land mid-frame
    pulse(0, 1, 12'h321);
    runFrame(3, 8'h99, 10, 1);
    runFrame(2, 8'hFF, 11, 0);
    // R9: reset mid-life clears counters and crossing value
    pulse(1, 1, 12'h777);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expAcc = 0; expRej = 0; expBc = '0;
    runFrame(1, 8'hFF, 12, 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule